// File: doc/BRIEF.md
# Read Strobe Delay Calibrator

This block finds a working read-strobe delay for each byte lane of a 32-bit DDR data path. On a start pulse it stores a fixed 32-bit pattern at one memory address. It then steps a shared delay value through one full clock period, expressed in degrees, and reads the address back once at every step. Each byte of every read-back word is compared on its own. The block records, for each lane, the lowest and the highest delay that gave a matching byte.

When the sweep ends, each lane's delay output is set to the centre of that lane's passing range. A lane that never matched raises its error flag and keeps the delay it had before the run. A one-cycle done pulse marks the end of calibration, and the delay outputs then stay fixed until the next start. While the sweep runs, the block drives the delay outputs itself so that the external delay lines follow the current step.

Top module: `rdqs_trainer`

## Requirements
- R1: There are four lane delays. Lane l covers data bits [8l+7:8l] and drives its delay on `dly_o[9l+8:9l]` as an unsigned degree value. The lanes are trained independently from the same reads.
- R2: A start pulse while idle causes exactly one write (`mem_we_o`=1) of PATTERN to TRAIN_ADDR before any read. Every request keeps `mem_req_o` high until the cycle in which `mem_ack_i` is seen.
- R3: After the write, reads (`mem_we_o`=0, same address) are issued at delays 0, 15, 30, … 360, which is 25 reads in increasing order. All four delay outputs equal the current step while that read is outstanding.
- R4: Each read waits for `mem_rvalid_i`. On that cycle, lane l passes if and only if byte l of `mem_rdata_i` equals byte l of PATTERN.
- R5: The new delay of a lane is min + (max - min)/2, with the division rounded down. Here min and max are the smallest and the largest step at which the lane passed.
- R6: A lane with no passing step sets `err_o[l]`=1 and keeps the delay value it had before the run. A lane that passed clears `err_o[l]`.
- R7: `done_o` is high for exactly one cycle, and in that cycle the new delays are already on `dly_o`. After it, `dly_o` and `err_o` stay unchanged until the next start.
- R8: A start pulse during calibration is ignored. It does not restart the sweep and does not add a write.
- R9: After reset, every lane delay is INIT_DLY (90), `err_o` is 0, and `done_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start calibration (pulse, used only when idle) |
| done_o | output | 1 | One-cycle end-of-calibration pulse |
| err_o | output | 4 | Per-lane no-window flag |
| dly_o | output | 36 | Four 9-bit lane delays in degrees |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Request address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
The hardest case to reach from the ports is four lanes ending in four different outcomes in one run: a wide window, a window that holds a single step, a window that starts or ends exactly at 0 or 360, and a lane that never passes. A second run must also show that an empty lane keeps a value trained in the run before. The bench memory model makes this happen by corrupting each byte of the read data according to a per-lane window of degrees. The window is tested against the delay outputs that the block is driving at the moment of the response. A stray start pulse is injected in the middle of a sweep to show that it has no effect.

// File: rtl/rdqs_pkg.sv
package rdqs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SET,
    ST_RREQ,
    ST_RWAIT,
    ST_APPLY
  } cal_st_t;
endpackage

// File: rtl/rdqs_sweep_ctrl.sv
module rdqs_sweep_ctrl
  import rdqs_pkg::*;
#(
  parameter int DEG_W    = 9,
  parameter int STEP_DEG = 15,
  parameter int FULL_DEG = 360
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             ack_i,
  input  logic             rvalid_i,
  output logic             req_o,
  output logic             we_o,
  output logic [DEG_W-1:0] phase_o,
  output logic             clr_o,
  output logic             set_o,
  output logic             sample_o,
  output logic             apply_o,
  output logic             idle_o
);
  localparam logic [DEG_W:0] STEP_V = (DEG_W+1)'(STEP_DEG);
  localparam logic [DEG_W:0] FULL_V = (DEG_W+1)'(FULL_DEG);

  cal_st_t        st;
  logic [DEG_W:0] nxt_phase;
  logic           last_step;

  assign nxt_phase = {1'b0, phase_o} + STEP_V;
  assign last_step = nxt_phase > FULL_V;
  assign clr_o     = (st == ST_IDLE) && start_i;
  assign set_o     = (st == ST_SET);
  assign sample_o  = (st == ST_RWAIT) && rvalid_i;
  assign apply_o   = (st == ST_APPLY);
  assign idle_o    = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      phase_o <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start_i) begin
          st      <= ST_WRITE;
          req_o   <= 1'b1;
          we_o    <= 1'b1;
          phase_o <= '0;
        end
        ST_WRITE: if (ack_i) begin
          req_o <= 1'b0;
          we_o  <= 1'b0;
          st    <= ST_SET;
        end
        ST_SET: begin
          req_o <= 1'b1;
          st    <= ST_RREQ;
        end
        ST_RREQ: if (ack_i) begin
          req_o <= 1'b0;
          st    <= ST_RWAIT;
        end
        ST_RWAIT: if (rvalid_i) begin
          if (last_step) st <= ST_APPLY;
          else begin
            phase_o <= nxt_phase[DEG_W-1:0];
            st      <= ST_SET;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> req_o);
  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_o && !last_step) |=> ({1'b0, phase_o} == {1'b0, $past(phase_o)} + STEP_V));
  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, phase_o} <= FULL_V);
endmodule

// File: rtl/rdqs_lane_window.sv
module rdqs_lane_window #(
  parameter int DEG_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             sample_i,
  input  logic             pass_i,
  input  logic [DEG_W-1:0] phase_i,
  output logic             found_o,
  output logic [DEG_W-1:0] mid_o
);
  logic [DEG_W-1:0] lo_q, hi_q, span;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      found_o <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (sample_i && pass_i) begin
      if (!found_o) lo_q <= phase_i;
      hi_q    <= phase_i;
      found_o <= 1'b1;
    end
  end

  assign span  = hi_q - lo_q;
  assign mid_o = lo_q + (span >> 1);

  // R5
  lo_le_hi_chk: assert property (@(posedge clk) disable iff (rst)
    found_o |-> (lo_q <= hi_q));
  // R5
  lo_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (found_o && !clr_i) |=> $stable(lo_q));
endmodule

// File: rtl/rdqs_trainer.sv
module rdqs_trainer
  import rdqs_pkg::*;
#(
  parameter int          LANES      = 4,
  parameter int          ADDR_W     = 16,
  parameter int          DEG_W      = 9,
  parameter int          STEP_DEG   = 15,
  parameter int          FULL_DEG   = 360,
  parameter int          INIT_DLY   = 90,
  parameter logic [15:0] TRAIN_ADDR = 16'h0040,
  parameter logic [31:0] PATTERN    = 32'hA53C_960F,
  localparam int         DATA_W     = LANES * 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  output logic                   done_o,
  output logic [LANES-1:0]       err_o,
  output logic [LANES*DEG_W-1:0] dly_o,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [DATA_W-1:0]      mem_wdata_o,
  input  logic                   mem_ack_i,
  input  logic                   mem_rvalid_i,
  input  logic [DATA_W-1:0]      mem_rdata_i
);
  localparam logic [DEG_W-1:0] INIT_V = DEG_W'(INIT_DLY);

  logic             clr, set, sample, apply, idle;
  logic [DEG_W-1:0] phase;

  assign mem_addr_o  = ADDR_W'(TRAIN_ADDR);
  assign mem_wdata_o = DATA_W'(PATTERN);

  rdqs_sweep_ctrl #(.DEG_W(DEG_W), .STEP_DEG(STEP_DEG), .FULL_DEG(FULL_DEG)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .ack_i(mem_ack_i),
    .rvalid_i(mem_rvalid_i), .req_o(mem_req_o), .we_o(mem_we_o),
    .phase_o(phase), .clr_o(clr), .set_o(set), .sample_o(sample),
    .apply_o(apply), .idle_o(idle)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic             pass, found;
    logic [DEG_W-1:0] mid, keep_q;

    assign pass = mem_rdata_i[l*8 +: 8] == mem_wdata_o[l*8 +: 8];

    rdqs_lane_window #(.DEG_W(DEG_W)) u_win (
      .clk(clk), .rst(rst), .clr_i(clr), .sample_i(sample), .pass_i(pass),
      .phase_i(phase), .found_o(found), .mid_o(mid)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        keep_q                 <= INIT_V;
        dly_o[l*DEG_W +: DEG_W] <= INIT_V;
        err_o[l]               <= 1'b0;
      end else if (apply) begin
        if (found) keep_q <= mid;
        dly_o[l*DEG_W +: DEG_W] <= found ? mid : keep_q;
        err_o[l]               <= !found;
      end else if (set) begin
        dly_o[l*DEG_W +: DEG_W] <= phase;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done_o <= 1'b0;
    else     done_o <= apply;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && !start_i) |=> ($stable(dly_o) && $stable(err_o)));
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (!idle && !apply) |=> !idle);
endmodule

// File: tb/rdqs_trainer_bench.sv
`timescale 1ns/1ps
module rdqs_trainer_bench;
  localparam logic [15:0] ADDR = 16'h0040;
  localparam logic [31:0] PAT  = 32'hA53C_960F;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic done, req, we, ack = 1'b0, rvalid = 1'b0;
  logic [3:0]  err;
  logic [35:0] dly;
  logic [15:0] addr;
  logic [31:0] wdata, rdata = '0;

  always #2.5 clk = ~clk;

  rdqs_trainer #(.TRAIN_ADDR(ADDR), .PATTERN(PAT)) u_rdqs_trainer (
    .clk(clk), .rst(rst), .start_i(start), .done_o(done), .err_o(err),
    .dly_o(dly), .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_ack_i(ack), .mem_rvalid_i(rvalid),
    .mem_rdata_i(rdata)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // memory model: per-lane passing window in degrees
  bit win_en[4];
  int win_lo[4], win_hi[4];
  int rd_cd = 0, wr_cnt = 0, rd_cnt = 0, seq_err = 0, rd_at_wr = -1;
  logic [31:0] wd_seen;
  logic [15:0] wa_seen;

  function automatic logic [31:0] make_data();
    logic [31:0] d;
    for (int l = 0; l < 4; l++) begin
      int p = int'(dly[l*9 +: 9]);
      if (win_en[l] && p >= win_lo[l] && p <= win_hi[l]) d[l*8 +: 8] = PAT[l*8 +: 8];
      else d[l*8 +: 8] = ~PAT[l*8 +: 8];
    end
    return d;
  endfunction

  always @(negedge clk) begin
    ack    <= 1'b0;
    rvalid <= 1'b0;
    if (rst) rd_cd = 0;
    else begin
      if (rd_cd > 0) begin
        rd_cd--;
        if (rd_cd == 0) begin
          rvalid <= 1'b1;
          rdata  <= make_data();
          for (int l = 0; l < 4; l++)
            if (int'(dly[l*9 +: 9]) != 15 * rd_cnt) seq_err++;
          rd_cnt++;
        end
      end
      if (req && !ack) begin
        ack <= 1'b1;
        if (we) begin
          wr_cnt++;
          wd_seen  = wdata;
          wa_seen  = addr;
          rd_at_wr = rd_cnt;
        end else begin
          if (addr != ADDR) seq_err++;
          rd_cd = 2;
        end
      end
    end
  end

  // scoreboard
  typedef struct { int d[4]; logic [3:0] e; } exp_t;
  exp_t q[$];
  int prev[4] = '{90, 90, 90, 90};
  int done_seen = 0;
  bit done_prev = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (done_prev && done) chk(1'b0, "R7 done width", 2, 1);
      if (done) begin
        exp_t x;
        done_seen++;
        if (q.size() == 0) chk(1'b0, "R7 unexpected done", 1, 0);
        else begin
          x = q.pop_front();
          for (int l = 0; l < 4; l++)
            chk(int'(dly[l*9 +: 9]) == x.d[l], $sformatf("R1 R5 R6 lane%0d delay", l),
                int'(dly[l*9 +: 9]), x.d[l]);
          chk(err == x.e, "R6 err flags", int'(err), int'(x.e));
        end
      end
    end
    done_prev = done;
  end

  task automatic run_cal(input bit stray);
    exp_t x;
    int n_done;
    for (int l = 0; l < 4; l++) begin
      int mn = -1, mx = -1;
      for (int p = 0; p <= 360; p += 15)
        if (win_en[l] && p >= win_lo[l] && p <= win_hi[l]) begin
          if (mn < 0) mn = p;
          mx = p;
        end
      if (mn < 0) begin x.d[l] = prev[l]; x.e[l] = 1'b1; end
      else begin x.d[l] = mn + (mx - mn) / 2; x.e[l] = 1'b0; prev[l] = x.d[l]; end
    end
    q.push_back(x);
    wr_cnt = 0; rd_cnt = 0; seq_err = 0; rd_at_wr = -1;
    n_done = done_seen;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (stray) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (done_seen == n_done) @(negedge clk);
    chk(wr_cnt == 1, "R2 R8 single write", wr_cnt, 1);
    chk(rd_at_wr == 0, "R2 write before reads", rd_at_wr, 0);
    chk(wd_seen == PAT, "R2 write data", int'(wd_seen), int'(PAT));
    chk(wa_seen == ADDR, "R2 write address", int'(wa_seen), int'(ADDR));
    chk(rd_cnt == 25, "R3 R4 read count", rd_cnt, 25);
    chk(seq_err == 0, "R3 sweep order", seq_err, 0);
    begin
      logic [35:0] d0 = dly;
      logic [3:0]  e0 = err;
      repeat (20) @(negedge clk);
      chk(dly == d0 && err == e0 && !req, "R7 hold after done", int'(dly[8:0]), int'(d0[8:0]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9
    for (int l = 0; l < 4; l++)
      chk(int'(dly[l*9 +: 9]) == 90, "R9 reset delay", int'(dly[l*9 +: 9]), 90);
    chk(err == 4'd0 && !done && !req, "R9 reset flags", int'(err), 0);

    // run 1: wide, full, single step, none
    win_en = '{1, 1, 1, 0};
    win_lo = '{30, 0, 100, 0};
    win_hi = '{200, 360, 110, 0};
    run_cal(1'b1);

    // run 2: empty lane keeps trained value, edges at 0 and 360
    win_en = '{0, 1, 1, 1};
    win_lo = '{0, 0, 15, 345};
    win_hi = '{0, 0, 40, 360};
    run_cal(1'b0);

    // run 3: all lanes fail, everything kept
    win_en = '{0, 0, 0, 0};
    run_cal(1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule